// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a simple single-port user interface and the command/address pins of a four-bank DDR SDRAM with a 16-bit data word. After reset it walks the memory through its power-up routine: it waits, closes every bank, programs the mode register with the chosen burst length, burst ordering and CAS latency, and gives two refresh cycles. Only then does it take user requests.

A user request carries a flat word address and a read/write flag. The address is split into bank, row and column. The block opens the row with ACTIVE, waits the row-to-column delay, and issues READ or WRITE with auto-precharge, so every access closes its bank by itself. At that moment it acknowledges the request. A free-running interval timer posts refresh demands. When the block is idle, a pending refresh wins over a new request, but it never splits an ACTIVE from its column command. For reads, a data-valid strobe is raised for one cycle per pair of beats, starting after the CAS latency rounded up to whole clocks.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held, the command lines show NOP, and ack, rd_valid and init_done are all low.
- R2: Each command is a 4-bit code {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE SET 0000. After reset the first command is PRECHARGE with a[10]=1. MODE SET follows T_RP cycles later. A REFRESH follows T_MRD cycles after that, and a second REFRESH T_RFC cycles after the first. init_done rises in the cycle of the second REFRESH. Neither PRECHARGE nor MODE SET appears again, and no ACTIVE, READ or WRITE appears before init_done.
- R3: The MODE SET command drives ba=0 and a word with the length code in a[2:0] (1, 2 or 3 for bursts of 2, 4 or 8). a[3] is set for interleaved ordering. The latency code is in a[6:4]: 2 for CL2, 3 for CL3 and 6 for CL2.5. All other bits are zero.
- R4: The request address is {bank[23:22], row[21:9], column[8:0]}. ACTIVE drives the bank on ba and the row on a.
- R5: READ (req_we=0) or WRITE (req_we=1) comes exactly T_RCD cycles after its ACTIVE, on the same ba. It drives the column on a[8:0], a[10]=1 and a[9], a[12:11] = 0. ack is high in that cycle and in no other.
- R6: The command after an ACTIVE is always its READ or WRITE. After a READ or WRITE, no command comes within BURST_LEN/2 + T_RP cycles.
- R7: No command comes within T_RFC cycles after a REFRESH. Once init_done is high, REFRESH commands are at most REF_INTERVAL + T_RCD + BURST_LEN/2 + T_RP + T_RFC cycles apart. An idle controller refreshes once every REF_INTERVAL cycles.
- R8: For a READ shown in cycle T, rd_valid is high in cycles T+ceil(CL) through T+ceil(CL)+BURST_LEN/2-1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request valid; held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat word address {bank, row, column} |
| ack | output | 1 | One-cycle pulse with the READ/WRITE command of the request |
| rd_valid | output | 1 | Read data expected on the memory data pins this cycle |
| init_done | output | 1 | Power-up routine finished; requests are served |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a | output | 13 | Row, column or mode word; a[10] is the auto-precharge / all-banks flag |

## Verification
Three configurations are run side by side: burst 4 interleaved at CL2.5, burst 8 sequential at CL2, and burst 2 sequential at CL3. This separates the three length codes and the three latency codes in the mode word, and shows the half-clock latency rounding up in the read strobe. Requests sweep every bank with both directions. The columns are zero, all-ones and a bank-dependent alternating pattern, and the rows are zero, all-ones and a mixed value. This exposes any swapped, shifted or truncated address field and any column bit that reaches the auto-precharge pin. Short and long pauses between requests let refresh deadlines fall both inside and outside accesses. A closing idle stretch shows the bare refresh cadence.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_LOADMODE,
    ST_INITREF,
    ST_IDLE,
    ST_COLUMN
  } sdr_state_e;

  // mode word: length code [2:0], ordering [3], latency code [6:4]
  function automatic logic [12:0] mode_word(input int bl, input int ilv, input int casx2);
    logic [2:0] len_code;
    logic [2:0] lat_code;
    len_code = (bl == 8) ? 3'd3 : (bl == 4) ? 3'd2 : 3'd1;
    lat_code = (casx2 == 5) ? 3'd6 : (casx2 == 6) ? 3'd3 : 3'd2;
    return {6'b0, lat_code, ilv[0], len_code};
  endfunction

endpackage

// File: rtl/sdr_addr_split.sv
module sdr_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign col  = addr[COL_W-1:0];
  assign row  = addr[COL_W +: ROW_W];
  assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 780,
  localparam int CNT_W = $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic pending
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             tick;

  assign tick = en && (cnt_q == CNT_W'(INTERVAL - 1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
    pend_d = (pend_q && !take) || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/sdr_rdvalid_pipe.sv
module sdr_rdvalid_pipe #(
  parameter int LAT   = 3,
  parameter int BEATS = 2,
  localparam int BC_W = $clog2(BEATS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic valid
);
  logic [LAT-1:0]  sr_q, sr_d;
  logic [BC_W-1:0] beat_q, beat_d;
  logic            launch;

  generate
    if (LAT == 1) begin : g_short
      assign sr_d = issue;
    end else begin : g_long
      assign sr_d = {sr_q[LAT-2:0], issue};
    end
  endgenerate

  assign launch = sr_q[LAT-1];

  always_comb begin
    if (launch)            beat_d = BC_W'(BEATS - 1);
    else if (beat_q != '0) beat_d = beat_q - 1'b1;
    else                   beat_d = beat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      beat_q <= '0;
    end else begin
      sr_q   <= sr_d;
      beat_q <= beat_d;
    end
  end

  assign valid = launch || (beat_q != '0);
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W           = 2,
  parameter int ROW_W            = 13,
  parameter int COL_W            = 9,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_X2           = 5,
  parameter int INIT_WAIT        = 20000,
  parameter int REF_INTERVAL     = 780,
  parameter int T_RCD            = 3,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 10,
  parameter int T_MRD            = 2,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ack,
  output logic              rd_valid,
  output logic              init_done,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a
);
  localparam int CL_CLK   = (CAS_X2 + 1) / 2;
  localparam int BEATS    = BURST_LEN / 2;
  localparam int AP_BIT   = 10;
  localparam int WAIT_MAX = INIT_WAIT + T_RFC + T_RCD + T_RP + BEATS + T_MRD;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  // reset synchroniser: assert at once, release after two edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  sdr_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .bank(req_bank), .row(req_row), .col(req_col)
  );

  logic ref_pend, ref_take;

  sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_reftmr (
    .clk(clk), .rst_n(rst_int_n), .en(init_done), .take(ref_take), .pending(ref_pend)
  );

  sdr_state_e        state_q, state_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  a_q, a_d;
  logic              ack_q, ack_d;
  logic              done_q, done_d;
  logic              iref_q, iref_d;
  logic              lat_en;
  logic [BANK_W-1:0] lat_bank_q;
  logic [COL_W-1:0]  lat_col_q;
  logic              lat_we_q;
  logic              wait_zero;

  assign wait_zero = (wait_q == '0);

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_zero ? wait_q : wait_q - 1'b1;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    a_d      = '0;
    ack_d    = 1'b0;
    done_d   = done_q;
    iref_d   = iref_q;
    lat_en   = 1'b0;
    ref_take = 1'b0;
    if (wait_zero) begin
      unique case (state_q)
        ST_POWER: begin
          cmd_d       = CMD_PRE;
          a_d[AP_BIT] = 1'b1;
          wait_d      = WAIT_W'(T_RP - 1);
          state_d     = ST_LOADMODE;
        end
        ST_LOADMODE: begin
          cmd_d   = CMD_MRS;
          a_d     = ROW_W'(mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_X2));
          wait_d  = WAIT_W'(T_MRD - 1);
          iref_d  = 1'b0;
          state_d = ST_INITREF;
        end
        ST_INITREF: begin
          cmd_d  = CMD_REF;
          wait_d = WAIT_W'(T_RFC - 1);
          if (iref_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            iref_d = 1'b1;
          end
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_d    = CMD_REF;
            wait_d   = WAIT_W'(T_RFC - 1);
            ref_take = 1'b1;
          end else if (req) begin
            cmd_d   = CMD_ACT;
            ba_d    = req_bank;
            a_d     = req_row;
            lat_en  = 1'b1;
            wait_d  = WAIT_W'(T_RCD - 1);
            state_d = ST_COLUMN;
          end
        end
        ST_COLUMN: begin
          cmd_d              = lat_we_q ? CMD_WR : CMD_RD;
          ba_d               = lat_bank_q;
          a_d[COL_W-1:0]     = lat_col_q;
          a_d[AP_BIT]        = 1'b1;
          ack_d              = 1'b1;
          wait_d             = WAIT_W'(BEATS + T_RP - 1);
          state_d            = ST_IDLE;
        end
        default: state_d = ST_POWER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_POWER;
      wait_q  <= WAIT_W'(INIT_WAIT);
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      a_q     <= '0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      iref_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      a_q     <= a_d;
      ack_q   <= ack_d;
      done_q  <= done_d;
      iref_q  <= iref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lat_bank_q <= '0;
      lat_col_q  <= '0;
      lat_we_q   <= 1'b0;
    end else if (lat_en) begin
      lat_bank_q <= req_bank;
      lat_col_q  <= req_col;
      lat_we_q   <= req_we;
    end
  end

  sdr_rdvalid_pipe #(.LAT(CL_CLK), .BEATS(BEATS)) u_rdpipe (
    .clk(clk), .rst_n(rst_int_n), .issue(cmd_q == CMD_RD), .valid(rd_valid)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba        = ba_q;
  assign a         = a_q;
  assign ack       = ack_q;
  assign init_done = done_q;
endmodule

// File: rtl/sdram_cmd_chk.sv
module sdram_cmd_chk
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W            = 13,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_X2           = 5,
  parameter int T_RCD            = 3,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [ROW_W-1:0] a,
  input logic             ack,
  input logic             rd_valid,
  input logic             init_done
);
  logic [3:0]  cmd;
  logic        is_rw, busy;
  logic [15:0] since_q;
  logic [3:0]  last_q;

  assign cmd   = {cs_n, ras_n, cas_n, we_n};
  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign busy  = (cmd != CMD_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 16'hFFFF;
      last_q  <= CMD_NOP;
    end else if (busy) begin
      since_q <= 16'd1;
      last_q  <= cmd;
    end else if (since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  assert_no_access_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !(is_rw || cmd == CMD_ACT));

  assert_mode_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> (a == ROW_W'(mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_X2))));

  assert_column_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (last_q == CMD_ACT && since_q == 16'(T_RCD)));

  assert_autoprecharge_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> a[10]);

  assert_ack_with_column_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> is_rw);

  assert_burst_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (last_q == CMD_RD || last_q == CMD_WR)) |-> (since_q >= 16'(BURST_LEN / 2 + T_RP)));

  assert_refresh_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_q == CMD_REF) |-> (since_q >= 16'(T_RFC)));

  assert_rdvalid_after_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> init_done);
endmodule

bind sdram_cmd_ctrl sdram_cmd_chk #(
  .ROW_W(ROW_W), .BURST_LEN(BURST_LEN), .BURST_INTERLEAVE(BURST_INTERLEAVE),
  .CAS_X2(CAS_X2), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .a(a), .ack(ack), .rd_valid(rd_valid), .init_done(init_done)
);

// File: tb/tb_lane.sv
module tb_lane #(
  parameter int BL    = 4,
  parameter int ILV   = 0,
  parameter int CASX2 = 5,
  parameter int ID    = 0
) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output bit   done
);
  import sdram_cmd_pkg::*;
  localparam int INIT_W = 12;
  localparam int REF_I  = 60;
  localparam int TRCD   = 3;
  localparam int TRP    = 2;
  localparam int TRFC   = 5;
  localparam int TMRD   = 2;
  localparam int CLR    = (CASX2 + 1) / 2;
  localparam int BEATS  = BL / 2;
  localparam int MW     = (((CASX2 == 5) ? 6 : (CASX2 == 6) ? 3 : 2) << 4)
                        | (ILV << 3) | ((BL == 8) ? 3 : (BL == 4) ? 2 : 1);

  logic        rst_n, req, req_we, ack, rd_valid, init_done;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [23:0] req_addr;
  logic [1:0]  ba;
  logic [12:0] a;

  sdram_cmd_ctrl #(
    .BURST_LEN(BL), .BURST_INTERLEAVE(ILV), .CAS_X2(CASX2), .INIT_WAIT(INIT_W),
    .REF_INTERVAL(REF_I), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .ack(ack), .rd_valid(rd_valid), .init_done(init_done),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a)
  );

  int   exp_bank, exp_row, exp_col, exp_we;
  bit   mark_req, fin_req;
  int   cyc = 0;
  int   step = 0;
  int   last_cyc = 0;
  int   last_ref = 0;
  int   last_rd = -1000;
  int   n_ref_op = 0;
  int   ref_mark = 0;
  bit   marked = 0;
  logic [3:0] last_cmd = CMD_NOP;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s lane%0d cyc%0d: actual=%0h expected=%0h", tag, ID, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] cmd;
    bit exp_rv;
    int gap;
    cyc++;
    cmd = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      chk(cmd == CMD_NOP && !ack && !rd_valid && !init_done, "R1",
          {cmd, ack, rd_valid, init_done}, {4'b0111, 3'b000});
    end else begin
      exp_rv = (cyc >= last_rd + CLR) && (cyc < last_rd + CLR + BEATS);
      if (rd_valid || exp_rv) chk(rd_valid == exp_rv, "R8", rd_valid, exp_rv);
      if (ack && !(cmd == CMD_RD || cmd == CMD_WR)) chk(1'b0, "R5", cmd, CMD_RD);
      if (cmd != CMD_NOP) begin
        gap = cyc - last_cyc;
        case (step)
          0: begin
            chk(cmd == CMD_PRE && a[10], "R2", {cmd, a[10]}, {CMD_PRE, 1'b1});
            step = 1;
          end
          1: begin
            chk(cmd == CMD_MRS && gap == TRP, "R2", gap, TRP);
            chk(a == 13'(MW) && ba == 2'd0, "R3", {ba, a}, MW);
            step = 2;
          end
          2: begin
            chk(cmd == CMD_REF && gap == TMRD && !init_done, "R2", gap, TMRD);
            step = 3;
          end
          3: begin
            chk(cmd == CMD_REF && gap == TRFC, "R2", gap, TRFC);
            chk(init_done == 1'b1, "R2", init_done, 1);
            last_ref = cyc;
            step = 4;
          end
          default: begin
            if (last_cmd == CMD_REF) chk(gap >= TRFC, "R7", gap, TRFC);
            if (last_cmd == CMD_RD || last_cmd == CMD_WR) chk(gap >= BEATS + TRP, "R6", gap, BEATS + TRP);
            case (cmd)
              CMD_ACT: begin
                chk(last_cmd != CMD_ACT, "R6", last_cmd, CMD_RD);
                chk(ba == 2'(exp_bank), "R4", ba, exp_bank);
                chk(a == 13'(exp_row), "R4", a, exp_row);
              end
              CMD_RD, CMD_WR: begin
                chk(last_cmd == CMD_ACT, "R6", last_cmd, CMD_ACT);
                chk(gap == TRCD, "R5", gap, TRCD);
                chk(ba == 2'(exp_bank), "R5", ba, exp_bank);
                chk(a == {2'b00, 1'b1, 1'b0, 9'(exp_col)}, "R5", a, {4'b0010, 9'(exp_col)});
                chk(cmd == (exp_we != 0 ? CMD_WR : CMD_RD), "R5", cmd, exp_we != 0 ? CMD_WR : CMD_RD);
                chk(ack == 1'b1, "R5", ack, 1);
                if (cmd == CMD_RD) last_rd = cyc;
              end
              CMD_REF: begin
                chk(last_cmd != CMD_ACT, "R6", last_cmd, CMD_NOP);
                chk(cyc - last_ref <= REF_I + TRCD + BEATS + TRP + TRFC, "R7",
                    cyc - last_ref, REF_I + TRCD + BEATS + TRP + TRFC);
                last_ref = cyc;
                n_ref_op++;
              end
              default: chk(1'b0, "R2", cmd, CMD_NOP);
            endcase
          end
        endcase
        last_cmd = cmd;
        last_cyc = cyc;
      end
      if (mark_req && !marked) begin
        ref_mark = n_ref_op;
        marked = 1;
      end
      if (fin_req && !done) begin
        chk(n_ref_op - ref_mark >= 3 && n_ref_op - ref_mark <= 4, "R7", n_ref_op - ref_mark, 3);
        done = 1;
      end
    end
  end

  initial begin
    rst_n = 0; req = 0; req_we = 0; req_addr = '0;
    exp_bank = 0; exp_row = 0; exp_col = 0; exp_we = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    wait (init_done);
    @(negedge clk); #1;
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < 3; k++) begin
          exp_bank = b;
          exp_we   = w;
          exp_row  = (k == 0) ? 0 : (k == 1) ? 8191 : ((b * 1237 + w * 977 + 371) % 8192);
          exp_col  = (k == 0) ? 0 : (k == 1) ? 511 : (9'h155 ^ b);
          req_addr = {2'(b), 13'(exp_row), 9'(exp_col)};
          req_we   = 1'(w);
          req      = 1;
          do @(negedge clk); while (!ack);
          #1 req = 0;
          repeat (k * 7) @(negedge clk);
          #1;
        end
      end
    end
    repeat (12) @(negedge clk);
    #1 mark_req = 1;
    repeat (3 * REF_I + 40) @(negedge clk);
    #1 fin_req = 1;
  end
endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk;
  int   c0, c1, c2, b0, b1, b2;
  bit   d0, d1, d2;
  int   wd;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  tb_lane #(.BL(4), .ILV(1), .CASX2(5), .ID(0)) lane0 (.clk(clk), .n_chk(c0), .n_bad(b0), .done(d0));
  tb_lane #(.BL(8), .ILV(0), .CASX2(4), .ID(1)) lane1 (.clk(clk), .n_chk(c1), .n_bad(b1), .done(d1));
  tb_lane #(.BL(2), .ILV(0), .CASX2(6), .ID(2)) lane2 (.clk(clk), .n_chk(c2), .n_bad(b2), .done(d2));

  initial begin
    int cycles;
    cycles = 0;
    wd = 0;
    while (!(d0 && d1 && d2) && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!(d0 && d1 && d2)) begin
      wd = 1;
      $display("FAIL watchdog R1..all: actual=%0d cycles expected=completion", cycles);
    end
    #1;
    $display("test done: total=%0d bad=%0d", c0 + c1 + c2 + wd, b0 + b1 + b2 + wd);
    $finish;
  end
endmodule